// File: doc/BRIEF.md
# Single-shot pulse timer

This block produces one output pulse per trigger. A run flag holds the state of the pulse. When the flag goes from 0 to 1, the output takes its active level and an up-counter starts again from zero. The counter advances only on clock cycles where the tick enable is high and the pause bit is clear. The pulse ends when software clears the run flag, or when the counter reaches the value in the compare register. A match also raises a sticky interrupt flag.

Software can start a pulse with a register write. An external trigger pin can also start one: the pin passes through a two-flop synchronizer and an edge detector, and the active edge (rising or falling) is selectable. Because a match clears the run flag inside the block, the pulse width equals the compare value in ticks. Software can still end the pulse early. A polarity bit inverts the output level.

Top module: `oneshot_timer`

## Requirements
- R1: Writing address 0 with data bit 0 = 1 while the run flag is 0 sets the run flag on the same clock edge that accepts the write. The pulse goes active from that edge, and the counter restarts from zero.
- R2: An active edge on `trig_in` starts a pulse with the same effect as a software start. The active edge is selected by configuration bit 2 (0 = rising, 1 = falling). The run flag rises on the third clock edge after the pin changes. An edge of the other direction starts nothing.
- R3: Writing address 0 with data bit 0 = 0 during a pulse ends it on the edge that accepts the write. The interrupt flag is not set.
- R4: For a compare value N of 1 or more, the pulse lasts exactly N counted ticks. It then ends by itself and `cmpa_flag` goes to 1.
- R5: Every new start resets the counter, so back-to-back pulses each get the full width.
- R6: While configuration bit 0 (pause) is 1, the counter holds its value and the pulse stays active. Clearing the bit resumes counting from the held value.
- R7: A start request (software write or pin edge) that arrives while a pulse is active is ignored. The pulse keeps its original end point.
- R8: When configuration bit 1 is 1, the output is inverted. Before inversion, the output is 0 out of reset and whenever no pulse is active.
- R9: A compare value of 0 gives a pulse of exactly one counted tick.
- R10: `cmpa_flag` is 0 after reset. Writing address 3 with data bit 0 = 1 clears it. Writing 0 there has no effect. The flag sets only on a compare match.
- R11: The counter advances only on cycles where `tick_en` is 1. Pulse width is counted in those ticks, not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 run, 1 configuration, 2 compare, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| trig_in | input | 1 | External trigger pin, asynchronous |
| pulse_out | output | 1 | Pulse output after polarity |
| cmpa_flag | output | 1 | Sticky compare-match interrupt flag |

## Verification
A wrong counter value or a missed counter reset shows up as a wrong pulse width, visible at the trailing edge of the same pulse. Every pulse is therefore measured in enabled, unpaused ticks and compared against its expected width. A run flag that is stuck, or that starts again by mistake, shows up as an extra pulse with nothing queued for it, or as a missing trailing edge that the bench reports after a bounded wait. Flag and idle-level errors appear one cycle after the write or match that should have changed them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_RUN  = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_CMPA = 2'd2,
    ADDR_FLAG = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic fall_edge;
    logic invert;
    logic hold;
  } tmr_cfg_t;

  localparam int CFG_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output tmr_cfg_t         cfg,
  output logic [CNT_W-1:0] cmpa,
  output logic             sw_set,
  output logic             sw_clr,
  output logic             flag_clr
);
  tmr_cfg_t         cfg_q, cfg_n;
  logic [CNT_W-1:0] cmpa_q, cmpa_n;
  tmr_addr_e        addr;

  assign addr = tmr_addr_e'(wr_addr);

  always_comb begin
    cfg_n  = cfg_q;
    cmpa_n = cmpa_q;
    if (wr_en && addr == ADDR_CFG)  cfg_n  = tmr_cfg_t'(wr_data[CFG_W-1:0]);
    if (wr_en && addr == ADDR_CMPA) cmpa_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmpa_q <= '0;
    end else begin
      cfg_q  <= cfg_n;
      cmpa_q <= cmpa_n;
    end
  end

  assign sw_set   = wr_en && addr == ADDR_RUN  &&  wr_data[0];
  assign sw_clr   = wr_en && addr == ADDR_RUN  && !wr_data[0];
  assign flag_clr = wr_en && addr == ADDR_FLAG &&  wr_data[0];
  assign cfg      = cfg_q;
  assign cmpa     = cmpa_q;
endmodule

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_act
);
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] hist_q, hist_n;
  logic              cur, prev;

  always_comb begin
    hist_n = {hist_q[HIST_W-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  assign cur      = hist_q[HIST_W-2];
  assign prev     = hist_q[HIST_W-1];
  assign edge_act = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             hold,
  input  logic [CNT_W-1:0] cmpa,
  input  logic             start,
  input  logic             sw_clr,
  input  logic             flag_clr,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q, run_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             flag_q, flag_n;

  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    flag_n = flag_q;
    if (flag_clr) flag_n = 1'b0;
    if (!run_q) begin
      if (start) begin
        run_n = 1'b1;
        cnt_n = '0;
      end
    end else if (sw_clr) begin
      run_n = 1'b0;
    end else if (tick_en && !hold) begin
      cnt_n = cnt_inc;
      if (cmpa == '0 || cnt_inc == cmpa) begin
        run_n  = 1'b0;
        flag_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end

  assign run  = run_q;
  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  output logic             pulse_out,
  output logic             cmpa_flag
);
  tmr_cfg_t         cfg;
  logic [CNT_W-1:0] cmpa;
  logic [CNT_W-1:0] cnt;
  logic             sw_set, sw_clr, flag_clr;
  logic             pin_edge, start, run, flag, hold_sig;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .cmpa     (cmpa),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .flag_clr (flag_clr)
  );

  tmr_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (trig_in),
    .fall_sel (cfg.fall_edge),
    .edge_act (pin_edge)
  );

  assign start    = sw_set | pin_edge;
  assign hold_sig = cfg.hold;

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .hold     (hold_sig),
    .cmpa     (cmpa),
    .start    (start),
    .sw_clr   (sw_clr),
    .flag_clr (flag_clr),
    .run      (run),
    .cnt      (cnt),
    .flag     (flag)
  );

  assign pulse_out = run ^ cfg.invert;
  assign cmpa_flag = flag;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             hold,
  input logic             start,
  input logic             sw_clr,
  input logic             flag_clr,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpa,
  input logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ticking;
  assign ticking = run && tick_en && !hold;

  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && start) |=> (run && cnt == '0));

  a_r3_sw_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sw_clr) |=> !run);

  a_r4_match_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ticking && !sw_clr && cmpa != '0 && (cnt + ONE) == cmpa) |=> (!run && flag));

  a_r6_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold && !sw_clr) |=> (run && $stable(cnt)));

  a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !(tick_en && !hold)) |=> $stable(cnt));

  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (!run && $stable(cnt)));

  a_r10_flag_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !ticking) |=> !flag);

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && flag_clr && !ticking) |=> !flag);
endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .hold     (hold_sig),
  .start    (start),
  .sw_clr   (sw_clr),
  .flag_clr (flag_clr),
  .run      (run),
  .cnt      (cnt),
  .cmpa     (cmpa),
  .flag     (flag)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;
  localparam int PERIOD = 10;
  localparam int W      = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         trig_in = 1'b0;
  logic         pulse_out, cmpa_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_wr_cyc = 0;
  int last_raw = 0;
  logic pol_tb = 1'b0;
  logic pause_tb = 1'b0;
  logic done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  oneshot_timer #(.CNT_W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig_in   (trig_in),
    .pulse_out (pulse_out),
    .cmpa_flag (cmpa_flag)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    last_wr_cyc = cyc;
    if (a == 2'd1) begin
      pause_tb = d[0];
      pol_tb   = d[1];
    end
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, {req, " pulse did not end"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    repeat (2) @(posedge clk);
    #1;
  endtask

  // monitor: measure each pulse in counted ticks and compare to the scoreboard
  initial begin
    logic prev_act;
    logic act;
    int   w;
    int   raw;
    prev_act = 1'b0; w = 0; raw = 0;
    forever begin
      @(negedge clk);
      act = pulse_out ^ pol_tb;
      if (rst_n && act) begin
        raw++;
        if (tick_en && !pause_tb) w++;
      end else if (prev_act) begin
        last_raw = raw;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected pulse", w, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(w == e, t, w, e);
        end
        w = 0; raw = 0;
      end
      prev_act = rst_n && act;
    end
  end

  initial begin
    #(PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1;
    repeat (3) @(posedge clk);
    #1;
    chk(pulse_out == 1'b0, "R8 reset output idle", pulse_out, 0);
    chk(cmpa_flag == 1'b0, "R10 reset flag clear", cmpa_flag, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R1/R4: software start, width 5
    wr(2'd2, 16'd5);
    push(5, "R4 width equals compare value 5");
    wr(2'd0, 16'd1);
    chk(pulse_out == 1'b1, "R1 software start raises pulse", pulse_out, 1);
    wait_done("R4");
    chk(cmpa_flag == 1'b1, "R4 match sets flag", cmpa_flag, 1);
    wr(2'd3, 16'd0);
    chk(cmpa_flag == 1'b1, "R10 writing 0 keeps flag", cmpa_flag, 1);
    wr(2'd3, 16'd1);
    chk(cmpa_flag == 1'b0, "R10 writing 1 clears flag", cmpa_flag, 0);

    // R9: compare 0 gives one tick
    wr(2'd2, 16'd0);
    push(1, "R9 compare zero one tick");
    wr(2'd0, 16'd1);
    wait_done("R9");
    wr(2'd3, 16'd1);

    // R5: back-to-back pulses get full width
    wr(2'd2, 16'd7);
    push(7, "R5 first pulse full width");
    wr(2'd0, 16'd1);
    wait_done("R5");
    push(7, "R5 second pulse full width");
    wr(2'd0, 16'd1);
    wait_done("R5");
    wr(2'd3, 16'd1);

    // R3: software cut
    wr(2'd2, 16'd40);
    wr(2'd0, 16'd1);
    t0 = last_wr_cyc;
    repeat (6) @(posedge clk);
    wr(2'd0, 16'd0);
    t1 = last_wr_cyc;
    push(t1 - t0, "R3 software clear width");
    wait_done("R3");
    chk(cmpa_flag == 1'b0, "R3 software clear leaves flag", cmpa_flag, 0);

    // R2: rising pin trigger
    wr(2'd2, 16'd4);
    push(4, "R2 rising pin trigger width");
    @(posedge clk); #1 trig_in = 1'b1;
    wait_done("R2");
    trig_in = 1'b0;
    repeat (4) @(posedge clk); #1;
    chk(pulse_out == 1'b0, "R2 opposite edge starts nothing", pulse_out, 0);
    wr(2'd3, 16'd1);

    // R2: falling edge select
    wr(2'd1, 16'd4);
    @(posedge clk); #1 trig_in = 1'b1;
    repeat (8) @(posedge clk); #1;
    chk(pulse_out == 1'b0, "R2 rising ignored when falling selected", pulse_out, 0);
    push(3, "R2 falling pin trigger width");
    wr(2'd2, 16'd3);
    trig_in = 1'b0;
    wait_done("R2");
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd1);

    // R7: retrigger attempts mid-pulse ignored
    wr(2'd2, 16'd12);
    push(12, "R7 retrigger ignored width");
    wr(2'd0, 16'd1);
    repeat (2) @(posedge clk); #1 trig_in = 1'b1;
    repeat (5) @(posedge clk);
    wr(2'd0, 16'd1);
    #1 trig_in = 1'b0;
    wait_done("R7");
    wr(2'd3, 16'd1);

    // R6: pause holds the count
    wr(2'd2, 16'd8);
    push(8, "R6 paused pulse tick width");
    wr(2'd0, 16'd1);
    repeat (2) @(posedge clk);
    wr(2'd1, 16'd1);
    t0 = last_wr_cyc;
    repeat (5) @(posedge clk);
    chk(pulse_out == 1'b1, "R6 pulse stays active while paused", pulse_out, 1);
    wr(2'd1, 16'd0);
    t1 = last_wr_cyc;
    wait_done("R6");
    chk(last_raw == 8 + (t1 - t0), "R6 pause stretches pulse", last_raw, 8 + (t1 - t0));
    wr(2'd3, 16'd1);

    // R11: tick enable gating
    wr(2'd2, 16'd4);
    push(4, "R11 width in enabled ticks");
    wr(2'd0, 16'd1);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1 tick_en = ~tick_en;
    end
    tick_en = 1'b1;
    wait_done("R11");
    chk(last_raw > 4, "R11 gated pulse longer in cycles", last_raw, 5);
    wr(2'd3, 16'd1);

    // R8: polarity
    wr(2'd1, 16'd2);
    chk(pulse_out == 1'b1, "R8 inverted idle level", pulse_out, 1);
    wr(2'd2, 16'd3);
    push(3, "R8 inverted pulse width");
    wr(2'd0, 16'd1);
    chk(pulse_out == 1'b0, "R8 inverted active level", pulse_out, 0);
    wait_done("R8");
    chk(pulse_out == 1'b1, "R8 inverted level after pulse", pulse_out, 1);
    wr(2'd1, 16'd0);
    chk(pulse_out == 1'b0, "R8 normal idle level", pulse_out, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule